// File: doc/BRIEF.md
# Port Pad Pull-Up and Open-Drain Controller

This block controls an eight-pin general-purpose port. Four byte-wide registers sit behind a small register bus: pin direction, output data, pull-up request and open-drain request. From those registers and a 3-bit operating-mode input the block drives four per-pin pad controls. These are output enable, low-side drive, high-side drive enable and pull-up enable.

The operating mode decides which requests take effect. In the two widest modes (6 and 7) every pull-up request is honoured. In any other mode only the top three pins may have a pull-up. Open-drain requests only act in mode 7. Elsewhere every output pin drives both high and low. Reads always return what was written, whatever the mode masks.

Two standby inputs change how the registers are kept. Hardware standby turns all pad drive and pull-ups off at once, with no clock edge needed, and clears the registers at the next edge. Software standby freezes the registers: bus writes are dropped and the contents are kept.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00 and every pad control output is 0.
- R2: A write with `bus_wr` high stores `bus_wdata` into the register chosen by `bus_addr`. The address codes are 0 = direction, 1 = output data, 2 = pull-up request and 3 = open-drain request. `bus_rdata` shows the chosen register while `bus_rd` is high and shows 0x00 otherwise.
- R3: A pin's pull-up enable is 1 only when all three hold: its direction bit is 0 (input), its pull-up request bit is 1, and the mode allows a pull-up on that pin. A pin set as output never has a pull-up.
- R4: In modes 6 and 7 pull-ups are allowed on all eight pins. In every other mode value, pull-ups are allowed only on pins 7, 6 and 5, and the pull-up enables of pins 4 to 0 stay 0.
- R5: Open-drain requests take effect only in mode 7. In every other mode an output pin behaves as push-pull, whatever the open-drain register holds.
- R6: In mode 7, an output pin whose open-drain bit is 1 keeps its high-side drive enable at 0. With data 0 it has output enable 1 and low-side drive 1. With data 1 its output enable is 0.
- R7: A push-pull output pin (direction bit 1, open-drain not in effect) has output enable 1 and high-side drive enable 1. Its low-side drive is the inverse of its data bit. An input pin has output enable, low-side drive and high-side drive enable all at 0.
- R8: While `hw_stby` is high, all pad control outputs are 0 in the same cycle it rises, with no clock edge needed. Every register reads 0x00 after the first clock edge that samples `hw_stby` high.
- R9: While `sw_stby` is high and `hw_stby` is low, bus writes are ignored and all four registers keep their contents.
- R10: Reading the pull-up or open-drain register returns the full stored byte, including bits that the current mode masks off.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operating mode |
| hw_stby | input | 1 | Hardware standby: outputs off at once, registers cleared |
| sw_stby | input | 1 | Software standby: registers frozen |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| pad_oe | output | 8 | Per-pin output enable |
| pad_lo_drv | output | 8 | Per-pin low-side (NMOS) drive |
| pad_hi_en | output | 8 | Per-pin high-side (PMOS) drive enable |
| pad_pu_en | output | 8 | Per-pin pull-up enable |

## Verification
The mode-dependent logic is tested in every mode from 4 to 7 in two ways. First, each of the 16 combinations of direction, data, pull-up and open-drain bits is applied to all pins at once; this covers every per-pin case in every mode. Second, mixed byte patterns give each pin a different combination, which shows up any pin-to-pin crossing and any error in the low-pin pull-up mask.

Modes 0 to 3 are also tried, to confirm they behave like the narrow pull-up, push-pull case. The standby tests set real drive first, so an output that stays active, or a register that is not cleared or not kept, can be seen.

// File: rtl/gpio_pad_pkg.sv
// Package: shared register-select encoding and mode constants for the
// pad controller. Assumes a 2-bit register address with four registers.
package gpio_pad_pkg;
    localparam int REG_COUNT = 4;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DOUT = 2'd1,
        SEL_PULL = 2'd2,
        SEL_ODRN = 2'd3
    } reg_sel_e;

    localparam int WIDE_PULL_MODE_A = 6;
    localparam int WIDE_PULL_MODE_B = 7;
    localparam int OPEN_DRAIN_MODE  = 7;
endpackage

// File: rtl/pad_reg_bank.sv
// Module: pad_reg_bank
// Holds the four per-pin control registers behind a byte-wide bus.
// Assumes: synchronous active-low reset; hardware standby clears on each
// edge it is sampled; software standby blocks writes only.
module pad_reg_bank
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_stby,
    input  logic                sw_stby,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] dout_q,
    output logic [NUM_PINS-1:0] pull_q,
    output logic [NUM_PINS-1:0] odrn_q
);
    localparam int NREG = REG_COUNT;

    logic [NREG-1:0][NUM_PINS-1:0] bank;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [NUM_PINS-1:0] q;
        // Purpose: clear on reset/hardware standby, else take a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n || hw_stby)
                q <= '0;
            else if (wr_en && !sw_stby && (addr == ADDR_W'(g)))
                q <= wdata;
        end
        assign bank[g] = q;
    end

    assign dir_q  = bank[SEL_DIR];
    assign dout_q = bank[SEL_DOUT];
    assign pull_q = bank[SEL_PULL];
    assign odrn_q = bank[SEL_ODRN];

    // Purpose: present the selected register while the read strobe is high.
    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = bank[addr];
    end

    a_r8_hw_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (bank == '0));

    a_r9_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(bank));
endmodule

// File: rtl/pad_mode_decode.sv
// Module: pad_mode_decode
// Turns the operating mode into a per-pin pull-up permission mask and an
// open-drain activation flag. Assumes mode values outside the wide pull-up
// set behave as the narrow case.
module pad_mode_decode
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int MODE_W      = 3,
    parameter int NARROW_LSB  = 5
) (
    input  logic [MODE_W-1:0]   mode,
    output logic [NUM_PINS-1:0] pull_ok,
    output logic                od_active
);
    logic wide_pull;

    // Purpose: classify the mode.
    always_comb begin
        wide_pull = (mode == MODE_W'(WIDE_PULL_MODE_A)) ||
                    (mode == MODE_W'(WIDE_PULL_MODE_B));
        od_active = (mode == MODE_W'(OPEN_DRAIN_MODE));
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
        if (i >= NARROW_LSB) begin : g_always
            assign pull_ok[i] = 1'b1;
        end else begin : g_wide_only
            assign pull_ok[i] = wide_pull;
        end
    end
endmodule

// File: rtl/pad_drive_slice.sv
// Module: pad_drive_slice
// Pad control for one pin. Assumes hardware standby must take effect
// combinationally, ahead of any register update.
module pad_drive_slice (
    input  logic dir_out,
    input  logic dout,
    input  logic pull_req,
    input  logic odrn_req,
    input  logic pull_ok,
    input  logic od_active,
    input  logic hw_stby,
    output logic oe,
    output logic lo_drv,
    output logic hi_en,
    output logic pu_en
);
    logic od_eff;
    logic float_hi;

    // Purpose: derive drive and pull-up controls for this pin.
    always_comb begin
        od_eff   = od_active && odrn_req;
        float_hi = od_eff && dout;
        oe       = !hw_stby && dir_out && !float_hi;
        lo_drv   = oe && !dout;
        hi_en    = oe && !od_eff;
        pu_en    = !hw_stby && !dir_out && pull_req && pull_ok;
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: gpio_pad_ctrl (top)
// Eight-pin port controller: register bank, mode decode and per-pin drive
// slices. Assumes a synchronous active-low reset and a 4-register bus.
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int MODE_W     = 3,
    parameter int ADDR_W     = 2,
    parameter int NARROW_LSB = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic                hw_stby,
    input  logic                sw_stby,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_lo_drv,
    output logic [NUM_PINS-1:0] pad_hi_en,
    output logic [NUM_PINS-1:0] pad_pu_en
);
    localparam int NARROW_PINS = (NARROW_LSB < NUM_PINS) ? NARROW_LSB : NUM_PINS;

    logic [NUM_PINS-1:0] dir_q, dout_q, pull_q, odrn_q, pull_ok;
    logic                od_active;

    pad_reg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .dir_q(dir_q), .dout_q(dout_q),
        .pull_q(pull_q), .odrn_q(odrn_q)
    );

    pad_mode_decode #(.NUM_PINS(NUM_PINS), .MODE_W(MODE_W),
                      .NARROW_LSB(NARROW_LSB)) u_mode (
        .mode(mode), .pull_ok(pull_ok), .od_active(od_active)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pad_drive_slice u_slice (
            .dir_out(dir_q[i]), .dout(dout_q[i]), .pull_req(pull_q[i]),
            .odrn_req(odrn_q[i]), .pull_ok(pull_ok[i]), .od_active(od_active),
            .hw_stby(hw_stby), .oe(pad_oe[i]), .lo_drv(pad_lo_drv[i]),
            .hi_en(pad_hi_en[i]), .pu_en(pad_pu_en[i])
        );
    end

    a_r3_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_en & dir_q) == '0);

    a_r4_low_pins_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_W'(WIDE_PULL_MODE_A) && mode != MODE_W'(WIDE_PULL_MODE_B))
        |-> (pad_pu_en[NARROW_PINS-1:0] == '0));

    a_r5_push_pull_outside_od: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_W'(OPEN_DRAIN_MODE)) |-> (pad_hi_en == pad_oe));

    a_r6_high_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_hi_en & ~pad_oe) == '0);

    a_r8_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> ((pad_oe | pad_lo_drv | pad_hi_en | pad_pu_en) == '0));
endmodule

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd7;
    logic       hw_stby = 1'b0, sw_stby = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pad_oe, pad_lo_drv, pad_hi_en, pad_pu_en;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    logic [7:0] m_reg [4];

    always #5 clk = ~clk;

    gpio_pad_ctrl u_gpio_pad_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_lo_drv(pad_lo_drv), .pad_hi_en(pad_hi_en),
        .pad_pu_en(pad_pu_en)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference register model
    always @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            for (int i = 0; i < 4; i++) m_reg[i] <= 8'h00;
        end else if (bus_wr && !sw_stby) begin
            m_reg[bus_addr] <= bus_wdata;
        end
    end

    // Reference pad outputs compared every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [7:0] e_oe, e_lo, e_hi, e_pu;
            bit od, wide;
            od   = (mode == 3'd7);
            wide = (mode == 3'd6) || (mode == 3'd7);
            for (int i = 0; i < 8; i++) begin
                e_oe[i] = 0; e_lo[i] = 0; e_hi[i] = 0; e_pu[i] = 0;
                if (!hw_stby) begin
                    if (m_reg[0][i]) begin
                        if (od && m_reg[3][i]) begin
                            e_oe[i] = !m_reg[1][i];
                            e_lo[i] = !m_reg[1][i];
                        end else begin
                            e_oe[i] = 1;
                            e_hi[i] = 1;
                            e_lo[i] = !m_reg[1][i];
                        end
                    end else begin
                        e_pu[i] = m_reg[2][i] && (wide || i >= 5);
                    end
                end
            end
            chk("R5 R6 R7 R8 oe", pad_oe, e_oe);
            chk("R6 R7 R8 lo_drv", pad_lo_drv, e_lo);
            chk("R5 R6 R7 R8 hi_en", pad_hi_en, e_hi);
            chk("R3 R4 R8 pu_en", pad_pu_en, e_pu);
            chk("R2 R10 rdata", bus_rdata, bus_rd ? m_reg[bus_addr] : 8'h00);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic load(logic [7:0] d, logic [7:0] o, logic [7:0] p, logic [7:0] q);
        wr(2'd0, d); wr(2'd1, o); wr(2'd2, p); wr(2'd3, q);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        @(negedge clk);
        chk("R1 reset oe", pad_oe, 8'h00);
        chk("R1 reset pu", pad_pu_en, 8'h00);
        rst_n = 1'b1;
        step();
        cmp_on = 1;
        for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1 reset register");

        // R2 address decode
        wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'h44); wr(2'd3, 8'h88);
        rd(2'd0, 8'h11, "R2 dir");
        rd(2'd1, 8'h22, "R2 dout");
        rd(2'd2, 8'h44, "R2 pull");
        rd(2'd3, 8'h88, "R2 odrn");

        // Sweep modes 4..7: uniform combos then mixed patterns (R3..R7)
        for (int m = 4; m < 8; m++) begin
            mode = 3'(m);
            for (int c = 0; c < 16; c++)
                load({8{c[0]}}, {8{c[1]}}, {8{c[2]}}, {8{c[3]}});
            for (int k = 0; k < 12; k++)
                load(8'(k * 37 + 3), 8'(k * 91 + 17), 8'(k * 53 + 200), 8'(k * 29 + 77));
        end
        // Modes 0..3 behave as narrow, push-pull (R4 R5)
        for (int m = 0; m < 4; m++) begin
            mode = 3'(m);
            load(8'h0F, 8'h05, 8'hFF, 8'hFF);
            load(8'hF0, 8'hA0, 8'hFF, 8'hFF);
        end

        // R6 explicit: mode 7 open-drain pin with data 1 floats
        mode = 3'd7;
        load(8'hFF, 8'hF0, 8'h00, 8'hFF);
        @(negedge clk);
        chk("R6 od oe", pad_oe, 8'h0F);
        chk("R6 od hi_en", pad_hi_en, 8'h00);
        step();

        // R10: masked bits still read back
        mode = 3'd4;
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'hFF, "R10 pull readback");
        rd(2'd3, 8'hFF, "R10 odrn readback");

        // R9: software standby holds contents
        load(8'h3C, 8'h5A, 8'hC3, 8'h81);
        sw_stby = 1'b1;
        wr(2'd0, 8'h00); wr(2'd1, 8'hFF); wr(2'd2, 8'h00); wr(2'd3, 8'h7E);
        rd(2'd0, 8'h3C, "R9 dir held");
        rd(2'd1, 8'h5A, "R9 dout held");
        rd(2'd2, 8'hC3, "R9 pull held");
        rd(2'd3, 8'h81, "R9 odrn held");
        sw_stby = 1'b0;

        // R8: hardware standby, immediate output shutdown then clear
        mode = 3'd7;
        load(8'h0F, 8'h03, 8'hFF, 8'h00);
        hw_stby = 1'b1;
        @(negedge clk);
        chk("R8 oe off at once", pad_oe, 8'h00);
        chk("R8 pu off at once", pad_pu_en, 8'h00);
        step();
        hw_stby = 1'b0;
        for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R8 cleared");

        // R8 wins over R9 when both standby inputs are high
        load(8'hAA, 8'h55, 8'h0F, 8'hF0);
        sw_stby = 1'b1; hw_stby = 1'b1;
        step();
        hw_stby = 1'b0;
        rd(2'd0, 8'h00, "R8 clear beats hold");
        sw_stby = 1'b0;
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule